// File: doc/BRIEF.md
# Single-Level Graphics Table Address Translator

This block turns a device virtual address into a physical address through a flat, single-level remapping table. The table lives in an external table memory. A request carries a virtual address and a byte length. The block works out which table slot covers the request's 4 KiB page and issues exactly one read for that slot. It then builds the physical address from the returned 64-bit entry and returns it together with a length. The length is trimmed so that the returned span never crosses a page boundary.

Table slots are not laid out in plain page order. The raw slot number is the page number, and seven times its three lowest bits are added to it before the memory is read. A slot that the table memory reports as absent does not raise a fault. The virtual address is handed back unchanged and a one-cycle warning pulse is raised. The table base and the start and end of the mapped range are static configuration inputs. The block reports the table base and the table size (end minus start) as plain outputs for neighbouring logic.

Only one table read is ever in flight. The request port stays not-ready from acceptance until the response has been taken. The response uses a valid/ready handshake and does not change while it waits.

Top module: `gart_translator`

## Requirements
- R1: After reset, reqReady is 1 and rspValid, tblRdValid and missWarn are all 0.
- R2: The table read address equals cfgPtBase + 8 * (P + 7 * P[2:0]), where P = vaddr[63:12] is the raw page number, with the sum taken modulo 2^64.
- R3: Each accepted request produces exactly one single-cycle tblRdValid pulse. reqReady stays 0 from acceptance until the response handshake completes.
- R4: When tblRspPresent is 1, rspPaddr is {16'b0, entry[47:12], vaddr[11:0]}. Entry bits 63:48 and 11:0 are ignored.
- R5: An entry value of zero with tblRspPresent at 1 is a valid mapping to physical page 0 and does not raise missWarn.
- R6: When tblRspPresent is 0, rspPaddr equals the request's vaddr, and missWarn is high for exactly the first cycle of that response. No other fault indication exists.
- R7: rspLen is the smaller of the requested length and 4096 - vaddr[11:0].
- R8: For a page-aligned vaddr (bits 11:0 zero), the clip distance is a full 4096 bytes.
- R9: While rspValid is 1 and rspReady is 0, rspValid stays 1 and rspPaddr and rspLen hold their values.
- R10: tableBase equals cfgPtBase, and tableSize equals cfgPtEnd - cfgPtStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 64 | Virtual address of the request |
| reqLen | input | 32 | Requested length in bytes |
| cfgPtBase | input | 64 | Byte address of table slot 0 |
| cfgPtStart | input | 64 | Start of the mapped range |
| cfgPtEnd | input | 64 | End of the mapped range |
| tblRdValid | output | 1 | One-cycle table read strobe |
| tblRdAddr | output | 64 | Byte address of the table slot read |
| tblRspValid | input | 1 | Table read data returned |
| tblRspEntry | input | 64 | Returned table entry |
| tblRspPresent | input | 1 | 1 when the slot holds a valid entry |
| rspValid | output | 1 | Translation result available |
| rspReady | input | 1 | Consumer accepts the result |
| rspPaddr | output | 64 | Translated physical address |
| rspLen | output | 32 | Length clipped to the page boundary |
| missWarn | output | 1 | One-cycle pulse on an absent entry |
| tableBase | output | 64 | Reported table base |
| tableSize | output | 64 | Reported table size (end minus start) |

## Verification
The translation is tried with page numbers whose low three bits are 0, 3, 5 and 7, so that a missing or wrongly scaled skew shows up in the table read address. One case has a page number above 2^20, which exposes truncated index arithmetic. The entry patterns separate the kinds of response. An entry with junk in bits 63:48 and 11:0 checks that those bits are masked. An all-zero entry that is marked present must still translate. An absent entry must pass the address through and pulse the warning. For the length, the offsets chosen are zero (full page), one byte before the boundary, and a distance exactly equal to the request, so that both sides of the minimum are observed. A held response under backpressure and a request offered while busy check the handshake rules.

// File: rtl/gart_pkg.sv
package gart_pkg;
  typedef struct packed {
    logic capReq;   // latch request fields
    logic issueRd;  // drive the table read strobe
    logic capRsp;   // latch table response, form result
  } gart_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } gart_state_t;
endpackage

// File: rtl/gart_ctrl.sv
module gart_ctrl
  import gart_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         tblRspValid,
  input  logic         rspReady,
  output logic         reqReady,
  output logic         rspValid,
  output gart_strobe_t strobe
);
  gart_state_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNxt = ST_ISSUE;
      ST_ISSUE: stateNxt = ST_WAIT;
      ST_WAIT:  if (tblRspValid) stateNxt = ST_RESP;
      ST_RESP:  if (rspReady) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    rspValid       = (state == ST_RESP);
    strobe.capReq  = (state == ST_IDLE) && reqValid;
    strobe.issueRd = (state == ST_ISSUE);
    strobe.capRsp  = (state == ST_WAIT) && tblRspValid;
  end
endmodule

// File: rtl/gart_datapath.sv
module gart_datapath
  import gart_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SKEW_BITS  = 3,
  parameter int ENTRY_LOG2 = 3,
  parameter int PA_HI      = 47
) (
  input  logic              clk,
  input  logic              rstN,
  input  gart_strobe_t      strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] cfgPtBase,
  input  logic [63:0]       tblRspEntry,
  input  logic              tblRspPresent,
  output logic              tblRdValid,
  output logic [ADDR_W-1:0] tblRdAddr,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [LEN_W-1:0]  rspLen,
  output logic              missWarn
);
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT;
  localparam int PAGE_SIZE = 1 << PAGE_SHIFT;
  localparam int DIST_W    = PAGE_SHIFT + 1;
  localparam int SKEW_MUL  = (1 << SKEW_BITS) - 1;
  localparam int PFN_W     = PA_HI - PAGE_SHIFT + 1;

  logic [ADDR_W-1:0] vaddrQ;
  logic [LEN_W-1:0]  lenQ;
  logic [IDX_W-1:0]  rawIdx, skewIdx;
  logic [DIST_W-1:0] pageDist;
  logic [LEN_W-1:0]  clipLen;
  logic [ADDR_W-1:0] hitPaddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      lenQ   <= '0;
    end else if (strobe.capReq) begin
      vaddrQ <= reqVaddr;
      lenQ   <= reqLen;
    end
  end

  // slot index: page number skewed by a multiple of its low bits
  always_comb begin
    rawIdx  = vaddrQ[ADDR_W-1:PAGE_SHIFT];
    skewIdx = rawIdx + IDX_W'(SKEW_MUL) * IDX_W'(rawIdx[SKEW_BITS-1:0]);
  end

  assign tblRdAddr  = cfgPtBase + (ADDR_W'(skewIdx) << ENTRY_LOG2);
  assign tblRdValid = strobe.issueRd;

  // distance to next page boundary; aligned addresses get a full page
  always_comb begin
    pageDist = DIST_W'(PAGE_SIZE) - DIST_W'(vaddrQ[PAGE_SHIFT-1:0]);
    if (lenQ > LEN_W'(pageDist)) clipLen = LEN_W'(pageDist);
    else                         clipLen = lenQ;
  end

  always_comb begin
    hitPaddr = '0;
    hitPaddr[PAGE_SHIFT-1:0]          = vaddrQ[PAGE_SHIFT-1:0];
    hitPaddr[PA_HI:PAGE_SHIFT]        = tblRspEntry[PA_HI:PAGE_SHIFT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspLen   <= '0;
      missWarn <= 1'b0;
    end else begin
      missWarn <= strobe.capRsp && !tblRspPresent;
      if (strobe.capRsp) begin
        rspPaddr <= tblRspPresent ? hitPaddr : vaddrQ;
        rspLen   <= clipLen;
      end
    end
  end

  // keep PFN_W referenced for width sanity of the entry field
  logic [PFN_W-1:0] unusedPfn;
  assign unusedPfn = tblRspEntry[PA_HI:PAGE_SHIFT];
  logic unusedBits;
  assign unusedBits = ^unusedPfn;
endmodule

// File: rtl/gart_translator.sv
module gart_translator
  import gart_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] cfgPtBase,
  input  logic [ADDR_W-1:0] cfgPtStart,
  input  logic [ADDR_W-1:0] cfgPtEnd,
  output logic              tblRdValid,
  output logic [ADDR_W-1:0] tblRdAddr,
  input  logic              tblRspValid,
  input  logic [63:0]       tblRspEntry,
  input  logic              tblRspPresent,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [LEN_W-1:0]  rspLen,
  output logic              missWarn,
  output logic [ADDR_W-1:0] tableBase,
  output logic [ADDR_W-1:0] tableSize
);
  gart_strobe_t strobe;

  gart_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tblRspValid(tblRspValid),
    .rspReady(rspReady), .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  gart_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr), .reqLen(reqLen),
    .cfgPtBase(cfgPtBase), .tblRspEntry(tblRspEntry), .tblRspPresent(tblRspPresent),
    .tblRdValid(tblRdValid), .tblRdAddr(tblRdAddr), .rspPaddr(rspPaddr),
    .rspLen(rspLen), .missWarn(missWarn)
  );

  assign tableBase = cfgPtBase;
  assign tableSize = cfgPtEnd - cfgPtStart;
endmodule

// File: rtl/gart_translator_chk.sv
module gart_translator_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              tblRdValid,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic [LEN_W-1:0]  rspLen,
  input logic              missWarn
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> reqReady && !rspValid && !tblRdValid && !missWarn); // R1
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rstN) tblRdValid |=> !tblRdValid); // R3
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rstN) tblRdValid |-> !reqReady); // R3
  AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> !reqReady); // R3
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> rspLen <= LEN_W'(4096)); // R7
  AST_WARN_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN) missWarn |-> rspValid); // R6
  AST_WARN_PULSE: assert property (@(posedge clk) disable iff (!rstN) missWarn |=> !missWarn); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspPaddr) && $stable(rspLen)); // R9
endmodule

bind gart_translator gart_translator_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .tblRdValid(tblRdValid),
  .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
  .rspLen(rspLen), .missWarn(missWarn)
);

// File: tb/tb_gart_translator.sv
module tb_gart_translator;
  typedef struct packed {
    logic [63:0] vaddr;
    logic [31:0] len;
    logic [63:0] entry;
    logic        present;
    logic [63:0] expAddr;
    logic [63:0] expPa;
    logic [31:0] expLen;
  } vec_t;

  localparam logic [63:0] BASE = 64'h0000_0001_0000_0000;
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0, 32'h100, 64'h0000_1234_5678_9000, 1'b1, BASE, 64'h0000_1234_5678_9000, 32'h100},
    '{64'h3123, 32'h2000, 64'hFFFF_ABCD_EF01_2FFF, 1'b1, BASE + 64'hC0, 64'h0000_ABCD_EF01_2123, 32'hEDD},
    '{64'h7FFF, 32'h5, 64'h0, 1'b0, BASE + 64'h1C0, 64'h7FFF, 32'h1},
    '{64'h8000, 32'h1000, 64'h0, 1'b1, BASE + 64'h40, 64'h0, 32'h1000},
    '{64'h1_0000_5800, 32'h800, 64'h0000_0000_0004_2000, 1'b1, BASE + 64'h80_0140, 64'h42800, 32'h800}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqReady, rspValid, rspReady = 1, missWarn;
  logic [63:0] reqVaddr = 0, tblRdAddr, rspPaddr, tableBase, tableSize;
  logic [31:0] reqLen = 0, rspLen;
  logic [63:0] cfgPtBase = BASE, cfgPtStart = 64'h0000_0000_0040_0000, cfgPtEnd = 64'h0000_0000_00C0_0000;
  logic tblRdValid, tblRspValid = 0, tblRspPresent = 0;
  logic [63:0] tblRspEntry = 0;
  logic [63:0] memEntry = 0, lastRdAddr = 0;
  logic memPresent = 0;
  int rdCount = 0, nChecks = 0, nFails = 0, cycles = 0;

  always #10 clk = ~clk;

  gart_translator dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    tblRspValid <= tblRdValid;
    tblRspEntry <= memEntry;
    tblRspPresent <= memPresent;
    if (tblRdValid) begin
      rdCount <= rdCount + 1;
      lastRdAddr <= tblRdAddr;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitRsp();
    int t = 0;
    while (!rspValid && t < 50) begin @(negedge clk); t++; end
  endtask

  task automatic sendReq(logic [63:0] va, logic [31:0] ln);
    @(negedge clk);
    reqVaddr = va; reqLen = ln; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    int t = 0;
    while (t < 20000) begin @(posedge clk); t++; end
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected<%0d", t, 20000);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reqReady", 64'(reqReady), 64'd1);
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 tblRdValid", 64'(tblRdValid), 64'd0);
    chk("R1 missWarn", 64'(missWarn), 64'd0);
    rstN = 1;
    chk("R10 tableBase", tableBase, BASE);
    chk("R10 tableSize", tableSize, 64'h0080_0000);

    for (int i = 0; i < NVEC; i++) begin
      int rd0;
      memEntry = VECS[i].entry; memPresent = VECS[i].present;
      rd0 = rdCount;
      sendReq(VECS[i].vaddr, VECS[i].len);
      waitRsp();
      chk("R2 tblRdAddr", lastRdAddr, VECS[i].expAddr);
      chk("R3 one read", 64'(rdCount - rd0), 64'd1);
      chk(VECS[i].present ? "R4/R5 paddr" : "R6 paddr", rspPaddr, VECS[i].expPa);
      chk("R7/R8 rspLen", 64'(rspLen), 64'(VECS[i].expLen));
      chk("R6 missWarn", 64'(missWarn), 64'(!VECS[i].present));
      @(negedge clk);
      chk("R6 warn pulse", 64'(missWarn), 64'd0);
    end

    // R9 backpressure and R3 busy-port
    begin
      logic [63:0] pa; logic [31:0] ln; int rd0;
      memEntry = VECS[1].entry; memPresent = 1;
      rspReady = 0;
      rd0 = rdCount;
      @(negedge clk);
      reqVaddr = VECS[1].vaddr; reqLen = VECS[1].len; reqValid = 1;
      @(negedge clk);
      reqVaddr = 64'hDEAD_0000; // offered while busy
      chk("R3 reqReady busy", 64'(reqReady), 64'd0);
      waitRsp();
      reqValid = 0;
      pa = rspPaddr; ln = rspLen;
      repeat (3) @(negedge clk);
      chk("R9 rspValid held", 64'(rspValid), 64'd1);
      chk("R9 paddr held", rspPaddr, pa);
      chk("R9 len held", 64'(rspLen), 64'(ln));
      chk("R9 paddr value", rspPaddr, VECS[1].expPa);
      chk("R3 reqReady while rsp", 64'(reqReady), 64'd0);
      chk("R3 reads during busy", 64'(rdCount - rd0), 64'd1);
      rspReady = 1;
      @(negedge clk);
      chk("R3 reqReady after accept", 64'(reqReady), 64'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule